// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address into a physical address when the translation cache misses. It reads a directory entry and then a table entry from memory. Along the way it records the accessed bit in each entry it uses, and on a write it records the dirty bit in the table entry. It then hands back either the physical address with the fill attributes or a page fault. A fault carries an error code, and the faulting linear address is kept in a capture register.

All memory traffic goes through one port that allows a single transaction at a time. A request holds its address and data until the memory acknowledges it. The caller starts a walk with a one-cycle request while the walker is idle. The caller supplies the linear address, the access direction, the current privilege level and the directory base. The result arrives as a one-cycle completion pulse.

Entry layout used throughout:

| Bit(s) | Meaning |
|--------|---------|
| 0 | present |
| 1 | writable |
| 2 | user |
| 5 | accessed |
| 6 | dirty |
| 31:12 | frame |

Top module: `pg_walker`

## Requirements
- R1: The directory entry is read from {base[31:12], lin[31:22], 2'b00}. The table entry is read from {dir_entry[31:12], lin[21:12], 2'b00}.
- R2: A successful walk gives phys_addr = {table_entry[31:12], lin[11:0]}, with done high for exactly one cycle.
- R3: A directory entry with bit 0 clear ends the walk with a fault, and no table entry is read.
- R4: A table entry with bit 0 clear ends the walk with a fault.
- R5: fault_addr takes the linear address of a faulting walk and keeps its value through every other walk.
- R6: Bit 5 is set in each entry that is used. An entry is written back only if its value changes, so entries that already have bit 5 set cost no write.
- R7: A write access sets bit 6 of the table entry in memory. Bit 6 of a directory entry is never set by the walker.
- R8: Privilege levels 0 to 2 complete the walk whatever the user and writable bits hold.
- R9: At privilege level 3 the effective user and writable bits are the AND of both entries. Effective user 0 faults any access, effective writable 0 faults a write, and a read with effective user 1 succeeds.
- R10: fault_code is {level 3 access, write access, protection (1) versus not present (0)}. It is valid with fault, and fault is only high with done. After a protection fault the table entry is left unchanged in memory.
- R11: mem_req, mem_addr, mem_we and mem_wdata hold steady from request until mem_ack, and only one transaction is outstanding.
- R12: After reset, busy, done, fault and mem_req are low and fault_addr is zero.
- R13: On success fill_attr is {dirty bit as left in memory, effective user, effective writable}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken while idle) |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access |
| req_cpl | input | 2 | Current privilege level |
| dir_base | input | 32 | 4 KB-aligned directory base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a page fault |
| fault_code | output | 3 | Fault error code |
| phys_addr | output | 32 | Translated address |
| fill_attr | output | 3 | {dirty, user, writable} for the cache fill |
| fault_addr | output | 32 | Captured faulting linear address |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back of an entry |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry value |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | 32 | Entry value read |

## Verification
The case that is hardest to reach from the ports is a level-3 walk where each entry alone would allow the access but their combination forbids it. A related case is a protection fault that must leave the table entry untouched even though it was fetched. The stimulus builds a directory entry that is read-only and user-accessible, pointing to a writable user table entry. It then issues a level-3 write, reads the memory model back, and checks that the directory accessed bit was written and the table entry was not. Memory latency is varied so that the request-hold rule is exercised across wait cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int P_BIT  = 0;
  localparam int RW_BIT = 1;
  localparam int US_BIT = 2;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WB_DIR,
    ST_RD_TBL,
    ST_WB_TBL
  } walk_st_t;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
  parameter int AW = 32,
  parameter int IW = 10,
  parameter int OW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] lin,
  input  logic [AW-1:0] dir_ent,
  output logic [AW-1:0] dir_addr,
  output logic [AW-1:0] tbl_addr
);
  localparam int EB = OW - IW;  // log2 of entry size in bytes

  assign dir_addr = {base[AW-1:OW],    lin[AW-1 -: IW],    {EB{1'b0}}};
  assign tbl_addr = {dir_ent[AW-1:OW], lin[AW-IW-1 -: IW], {EB{1'b0}}};
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
  import pgw_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] dir_ent,
  input  logic [EW-1:0] tbl_ent,
  input  logic          is_user,
  input  logic          is_write,
  output logic          eff_rw,
  output logic          eff_us,
  output logic          ok
);
  // the more restrictive of the two levels wins
  assign eff_rw = dir_ent[RW_BIT] & tbl_ent[RW_BIT];
  assign eff_us = dir_ent[US_BIT] & tbl_ent[US_BIT];
  assign ok     = !is_user || (eff_us && (eff_rw || !is_write));
endmodule

// File: rtl/pg_walker.sv
module pg_walker
  import pgw_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 10,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_lin,
  input  logic          req_write,
  input  logic [1:0]    req_cpl,
  input  logic [AW-1:0] dir_base,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [2:0]    fault_code,
  output logic [AW-1:0] phys_addr,
  output logic [2:0]    fill_attr,
  output logic [AW-1:0] fault_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  localparam logic [AW-1:0] ONE    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] A_MASK = ONE << A_BIT;
  localparam logic [AW-1:0] D_MASK = ONE << D_BIT;

  walk_st_t      state;
  logic [AW-1:0] lin_q, base_q, pde_q, pte_q;
  logic          wr_q, usr_q;

  logic [AW-1:0] dir_addr, tbl_addr;
  logic [AW-1:0] tbl_cur, tbl_upd;
  logic          eff_rw, eff_us, perm_ok;
  logic [AW-1:0] fin_phys;
  logic [2:0]    fin_attr;

  pgw_addr #(.AW(AW), .IW(IW), .OW(OW)) u_addr (
    .base(base_q), .lin(lin_q), .dir_ent(pde_q),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr)
  );

  assign tbl_cur = (state == ST_RD_TBL) ? mem_rdata : pte_q;
  assign tbl_upd = tbl_cur | A_MASK | (wr_q ? D_MASK : '0);

  pgw_perm #(.EW(AW)) u_perm (
    .dir_ent(pde_q), .tbl_ent(tbl_cur), .is_user(usr_q), .is_write(wr_q),
    .eff_rw(eff_rw), .eff_us(eff_us), .ok(perm_ok)
  );

  assign fin_phys = {tbl_upd[AW-1:OW], lin_q[OW-1:0]};
  assign fin_attr = {tbl_upd[D_BIT], eff_us, eff_rw};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_DIR: begin mem_req = 1'b1; mem_addr = dir_addr; end
      ST_WB_DIR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dir_addr; mem_wdata = pde_q; end
      ST_RD_TBL: begin mem_req = 1'b1; mem_addr = tbl_addr; end
      ST_WB_TBL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr; mem_wdata = pte_q; end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lin_q      <= '0;
      base_q     <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      phys_addr  <= '0;
      fill_attr  <= '0;
      fault_addr <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          base_q <= dir_base;
          wr_q   <= req_write;
          usr_q  <= (req_cpl == 2'd3);
          state  <= ST_RD_DIR;
        end
        ST_RD_DIR: if (mem_ack) begin
          pde_q <= mem_rdata | A_MASK;
          if (!mem_rdata[P_BIT]) begin
            done       <= 1'b1;
            fault      <= 1'b1;
            fault_code <= {usr_q, wr_q, 1'b0};
            fault_addr <= lin_q;
            state      <= ST_IDLE;
          end else if (!mem_rdata[A_BIT]) begin
            state <= ST_WB_DIR;
          end else begin
            state <= ST_RD_TBL;
          end
        end
        ST_WB_DIR: if (mem_ack) state <= ST_RD_TBL;
        ST_RD_TBL: if (mem_ack) begin
          pte_q <= tbl_upd;
          if (!mem_rdata[P_BIT] || !perm_ok) begin
            done       <= 1'b1;
            fault      <= 1'b1;
            fault_code <= {usr_q, wr_q, mem_rdata[P_BIT]};
            fault_addr <= lin_q;
            state      <= ST_IDLE;
          end else if (tbl_upd != mem_rdata) begin
            state <= ST_WB_TBL;
          end else begin
            done      <= 1'b1;
            phys_addr <= fin_phys;
            fill_attr <= fin_attr;
            state     <= ST_IDLE;
          end
        end
        ST_WB_TBL: if (mem_ack) begin
          done      <= 1'b1;
          phys_addr <= fin_phys;
          fill_attr <= fin_attr;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pg_walker_chk.sv
module pg_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          fault,
  input logic [AW-1:0] fault_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> done); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[pgw_pkg::A_BIT]); // R6

  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(done && fault) |-> (fault_addr == $past(fault_addr))); // R5
endmodule

bind pg_walker pg_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .fault(fault), .fault_addr(fault_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_pg_walker.sv
`timescale 1ns/1ps
module sim_pg_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic [31:0] dir_base = '0;
  logic        busy, done, fault;
  logic [2:0]  fault_code, fill_attr;
  logic [31:0] phys_addr, fault_addr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #5 clk = ~clk;

  pg_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_cpl(req_cpl), .dir_base(dir_base),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
    .phys_addr(phys_addr), .fill_attr(fill_attr), .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: 16 KB, word indexed by addr[13:2]
  logic [31:0] mem_arr [0:4095];
  int          lat = 0;
  int          cnt = 0;
  int          rd_cnt = 0, wr_cnt = 0, proto_err = 0;
  logic        req_d = 1'b0;
  logic        poke_en = 1'b0;
  logic [31:0] poke_addr = '0, poke_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      cnt       <= 0;
      req_d     <= 1'b0;
      for (int i = 0; i < 4096; i++) mem_arr[i] <= '0;
    end else begin
      req_d <= mem_req && !mem_ack;
      if (req_d && !mem_req) proto_err++;
      if (poke_en) mem_arr[poke_addr[13:2]] <= poke_data;
      if (mem_ack) begin
        mem_ack <= 1'b0;
        cnt     <= 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem_arr[mem_addr[13:2]] <= mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata <= mem_arr[mem_addr[13:2]];
            rd_cnt++;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  int total = 0, bad = 0;
  int rd0, wr0;

  localparam logic [31:0] EP = 32'h1, ERW = 32'h2, EUS = 32'h4;

  function automatic logic [31:0] mk_lin(input int d, input int t, input int o);
    logic [31:0] dv, tv, ov;
    dv = d; tv = t; ov = o;
    return {dv[9:0], tv[9:0], ov[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem_arr[a[13:2]];
  endfunction

  task automatic walk(input logic [31:0] base, input logic [31:0] lin,
                      input logic wr, input logic [1:0] cpl);
    int n;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    dir_base = base; req_lin = lin; req_write = wr; req_cpl = cpl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("walk timeout", 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    chk("R12 busy", {31'd0, busy}, 32'd0);
    chk("R12 done", {31'd0, done}, 32'd0);
    chk("R12 fault", {31'd0, fault}, 32'd0);
    chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12 fault_addr", fault_addr, 32'd0);
  endtask

  task automatic t_fresh_read;
    poke(32'h0000_0004, 32'h0000_1000 | EP | ERW | EUS);
    poke(32'h0000_1008, 32'hABCD_E000 | EP | ERW | EUS);
    walk(32'h0, mk_lin(1, 2, 12'h345), 1'b0, 2'd0);
    chk("R2 fault", {31'd0, fault}, 32'd0);
    chk("R2 phys", phys_addr, 32'hABCD_E345);
    chk("R13 attr", {29'd0, fill_attr}, 32'd3);
    chk("R6 writes", wr_cnt - wr0, 32'd2);
    chk("R6 dir accessed", peek(32'h4), 32'h0000_1027);
    chk("R7 read no dirty", peek(32'h1008), 32'hABCD_E027);
    @(negedge clk);
    chk("R2 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_repeat;
    walk(32'h0, mk_lin(1, 2, 12'h345), 1'b0, 2'd0);
    chk("R6 no rewrite", wr_cnt - wr0, 32'd0);
    chk("R2 phys repeat", phys_addr, 32'hABCD_E345);
  endtask

  task automatic t_user_write;
    walk(32'h0, mk_lin(1, 2, 12'h001), 1'b1, 2'd3);
    chk("R9 user write ok", {31'd0, fault}, 32'd0);
    chk("R7 one write", wr_cnt - wr0, 32'd1);
    chk("R7 table dirty", peek(32'h1008), 32'hABCD_E067);
    chk("R7 dir no dirty", peek(32'h4), 32'h0000_1027);
    chk("R13 attr dirty", {29'd0, fill_attr}, 32'd7);
  endtask

  task automatic t_dir_absent;
    walk(32'h0, mk_lin(5, 0, 12'h010), 1'b1, 2'd3);
    chk("R3 fault", {31'd0, fault}, 32'd1);
    chk("R3 one read", rd_cnt - rd0, 32'd1);
    chk("R10 code", {29'd0, fault_code}, 32'd6);
    chk("R5 capture", fault_addr, mk_lin(5, 0, 12'h010));
    walk(32'h0, mk_lin(1, 2, 12'h345), 1'b0, 2'd0);
    chk("R5 hold", fault_addr, mk_lin(5, 0, 12'h010));
  endtask

  task automatic t_tbl_absent;
    poke(32'h0000_0018, 32'h0000_2000 | EP | ERW | EUS);
    walk(32'h0, mk_lin(6, 7, 0), 1'b0, 2'd0);
    chk("R4 fault", {31'd0, fault}, 32'd1);
    chk("R4 code", {29'd0, fault_code}, 32'd0);
    chk("R4 dir written", wr_cnt - wr0, 32'd1);
    chk("R5 capture2", fault_addr, mk_lin(6, 7, 0));
  endtask

  task automatic t_user_super;
    poke(32'h0000_2020, 32'h5555_5000 | EP | ERW);
    walk(32'h0, mk_lin(6, 8, 12'h123), 1'b0, 2'd3);
    chk("R9 super page fault", {31'd0, fault}, 32'd1);
    chk("R10 code user prot", {29'd0, fault_code}, 32'd5);
    chk("R10 table untouched", peek(32'h2020), 32'h5555_5003);
    walk(32'h0, mk_lin(6, 8, 12'h123), 1'b0, 2'd2);
    chk("R8 level2 ok", {31'd0, fault}, 32'd0);
    chk("R8 phys", phys_addr, 32'h5555_5123);
    chk("R13 attr super", {29'd0, fill_attr}, 32'd1);
  endtask

  task automatic t_read_only;
    poke(32'h0000_2024, 32'h6666_6000 | EP | EUS);
    walk(32'h0, mk_lin(6, 9, 12'h007), 1'b0, 2'd3);
    chk("R9 ro read ok", {31'd0, fault}, 32'd0);
    chk("R13 attr ro", {29'd0, fill_attr}, 32'd2);
    walk(32'h0, mk_lin(6, 9, 12'h007), 1'b1, 2'd3);
    chk("R9 ro write fault", {31'd0, fault}, 32'd1);
    chk("R10 code ro", {29'd0, fault_code}, 32'd7);
    chk("R10 no dirty on fault", peek(32'h2024), 32'h6666_6025);
    walk(32'h0, mk_lin(6, 9, 12'h007), 1'b1, 2'd0);
    chk("R8 level0 write ok", {31'd0, fault}, 32'd0);
    chk("R8 dirty set", peek(32'h2024), 32'h6666_6065);
  endtask

  task automatic t_restrict;
    poke(32'h0000_001C, 32'h0000_1000 | EP | EUS);
    poke(32'h0000_100C, 32'h7777_7000 | EP | ERW | EUS);
    walk(32'h0, mk_lin(7, 3, 0), 1'b1, 2'd3);
    chk("R9 combined ro fault", {31'd0, fault}, 32'd1);
    chk("R10 code combined", {29'd0, fault_code}, 32'd7);
    chk("R6 dir accessed on fault", peek(32'h1C), 32'h0000_1025);
    chk("R10 table kept", peek(32'h100C), 32'h7777_7007);
    walk(32'h0, mk_lin(7, 3, 0), 1'b0, 2'd3);
    chk("R9 combined read ok", phys_addr, 32'h7777_7000);
    chk("R13 attr combined", {29'd0, fill_attr}, 32'd2);
  endtask

  task automatic t_base;
    lat = 3;  // R11 wait cycles on every transaction
    poke(32'h0000_3004, 32'h0000_2000 | EP | ERW | EUS);
    poke(32'h0000_2004, 32'h1234_5000 | EP | ERW | EUS);
    walk(32'h0000_3000, mk_lin(1, 1, 12'hFFF), 1'b0, 2'd1);
    chk("R1 phys via base", phys_addr, 32'h1234_5FFF);
    chk("R1 dir entry at base", peek(32'h3004), 32'h0000_2027);
    chk("R1 other dir untouched", peek(32'h4), 32'h0000_1027);
    chk("R1 table entry", peek(32'h2004), 32'h1234_5027);
    lat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_fresh_read;
    t_repeat;
    t_user_write;
    t_dir_absent;
    t_tbl_absent;
    t_user_super;
    t_read_only;
    t_restrict;
    t_base;
    chk("R11 request held to ack", proto_err, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule